// File: doc/BRIEF.md
# Smart card session sequencer

This block sequences the contacts of a smart card socket through a power-up and power-down order. Each step sits on a grid of half-unit ticks. A tick is a fixed number of system clocks, set by a parameter, and defaults to about 12.5 µs. The host starts a session by pulling an active-low start command. It ends the session by releasing that command or by dropping the mode input into sleep. The block drives enables for the step-up converter, the card supply, the I/O lines and the card clock. It also drives the card reset line, an active-low interrupt and a three-bit state code.

Every output is a register. Each one is loaded from a decode of the sequencer state and a step counter, so the outputs cannot glitch between steps. Several conditions force the same power-down order as a normal end of session: over-current, over-temperature, a low supply, or loss of the card. In that case the interrupt stays low until the release rules are met. Entering sleep first runs a full power-down. Leaving sleep waits a fixed number of slow-clock periods.

Top module: `card_session_seq`

## Requirements
- R1: State codes on `stateOut` are 0 idle, 1 low-power, 2 activation, 3 active, 4 deactivation, 5 fault. From idle, `cmdN` low with `modeNormal` high starts activation. While `modeNormal` is low, no activation starts and `boostEn` stays low.
- R2: Activation steps are counted in ticks from entry to activation. `boostEn` rises at tick 0 and `vccEn` at tick 3. `ioEn` rises at tick 8, which is where the clock window opens. Reset control is handed over at tick 14, where the sequencer becomes active.
- R3: `clkEn` rises only if `hostRst` is high during activation ticks 8 to 13. A high `hostRst` before tick 8 has no effect on `clkEn`.
- R4: Deactivation starts when `cmdN` goes high or `modeNormal` goes low. `cardRst` falls at tick 0, `clkEn` at tick 1, `ioEn` at tick 2, `vccEn` at tick 3 and `boostEn` at tick 10. The sequencer then returns to idle. No enable rises during deactivation.
- R5: Any of `overCurrent`, `overTemp`, `supplyLow` or a low `cardPresent` during activation or active operation drives `intN` low and starts deactivation. After that deactivation the state is fault.
- R6: The fault state is left for idle, with `intN` returning high, only when `cmdN` is high and `cardPresent` is high. With the card absent, `intN` stays low.
- R7: A fault during activation aborts from the step already reached. Enables that had not yet risen stay low.
- R8: `modeNormal` low during a session runs a normal deactivation, with `intN` high, and then enters low-power. Once `modeNormal` returns high, idle is re-entered after WAKE_CYCLES times TICKS_PER_SLOW ticks. A low pulse on `modeNormal` restarts that count.
- R9: While `rstN` is low, all enables and `cardRst` are low, `intN` is high and the state is idle.
- R10: From activation tick 14 onward, `cardRst` is the inverse of `hostRst`, with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdN | input | 1 | Session start command, active low |
| modeNormal | input | 1 | High for normal operation, low for sleep |
| hostRst | input | 1 | Reset request from the host |
| cardPresent | input | 1 | High while a card is inserted |
| overCurrent | input | 1 | Card supply over-current flag |
| overTemp | input | 1 | Over-temperature flag |
| supplyLow | input | 1 | Host supply below threshold |
| boostEn | output | 1 | Step-up converter enable |
| vccEn | output | 1 | Card supply enable |
| ioEn | output | 1 | I/O line release (low holds the lines low) |
| clkEn | output | 1 | Card clock enable |
| cardRst | output | 1 | Card reset line |
| intN | output | 1 | Interrupt to the host, active low |
| stateOut | output | 3 | Sequencer state code |

## Verification
The assertions assume that all inputs are synchronous to `clk` and change only between edges. They also assume that the fault flags are levels, not single-cycle spikes that come and go inside one tick. The bench changes every input on a falling clock edge and holds each fault flag for several cycles. It samples the outputs in the middle of a tick, never on a step boundary. The ordering properties (supply behind the converter, lines behind the supply, clock and reset behind the lines) rely on the host never forcing a contact on from outside. The stimulus only ever uses the command, mode and fault inputs to drive the contacts.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SLEEP = 3'd1,
    ST_ACT   = 3'd2,
    ST_ON    = 3'd3,
    ST_DOWN  = 3'd4,
    ST_FAULT = 3'd5
  } seqState_t;

  // Step positions on the half-unit tick grid
  localparam int ACT_VCC_STEP = 3;
  localparam int ACT_IO_STEP  = 8;
  localparam int ACT_RST_STEP = 14;
  localparam int DN_CLK_STEP  = 1;
  localparam int DN_IO_STEP   = 2;
  localparam int DN_VCC_STEP  = 3;
  localparam int DN_END_STEP  = 10;

  typedef struct packed {
    logic      clrStep;
    seqState_t phase;
  } seqStrobe_t;

  typedef struct packed {
    logic boost;
    logic vcc;
    logic io;
    logic clk;
    logic rstEn;
  } contactEn_t;

endpackage

// File: rtl/scs_timebase.sv
`timescale 1ns/1ps
module scs_timebase #(
  parameter int TICK_CLKS = 125,
  parameter int STEP_W    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  output logic [STEP_W-1:0] step
);
  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CLKS - 1);

  logic [PW-1:0] preCnt;
  logic          tick;

  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      step   <= '0;
    end else if (clr) begin
      preCnt <= '0;
      step   <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick && (step != '1)) step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/scs_ctrl.sv
`timescale 1ns/1ps
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int STEP_W     = 9,
  parameter int WAKE_TICKS = 480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdN,
  input  logic              modeNormal,
  input  logic              cardPresent,
  input  logic              overCurrent,
  input  logic              overTemp,
  input  logic              supplyLow,
  input  logic [STEP_W-1:0] step,
  output seqStrobe_t        strobe,
  output seqState_t         state,
  output logic              intN
);
  seqState_t stateNext;
  logic      emerg;
  logic      emergNext;
  logic      faultAny;
  logic      powered;
  logic      stopReq;

  assign faultAny = overCurrent | overTemp | supplyLow | ~cardPresent;
  assign powered  = (state == ST_ACT) || (state == ST_ON) || (state == ST_DOWN);
  assign stopReq  = cmdN | ~modeNormal;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (!modeNormal)  stateNext = ST_SLEEP;
        else if (!cmdN)   stateNext = ST_ACT;
      end
      ST_SLEEP: begin
        if (modeNormal && (step == STEP_W'(WAKE_TICKS))) stateNext = ST_IDLE;
      end
      ST_ACT: begin
        if (faultAny || stopReq)                    stateNext = ST_DOWN;
        else if (step == STEP_W'(ACT_RST_STEP))     stateNext = ST_ON;
      end
      ST_ON: begin
        if (faultAny || stopReq) stateNext = ST_DOWN;
      end
      ST_DOWN: begin
        if (step == STEP_W'(DN_END_STEP)) begin
          if (emerg || faultAny) stateNext = ST_FAULT;
          else if (!modeNormal)  stateNext = ST_SLEEP;
          else                   stateNext = ST_IDLE;
        end
      end
      ST_FAULT: begin
        if (cmdN && cardPresent) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    emergNext = emerg;
    if (powered && faultAny)                          emergNext = 1'b1;
    else if ((state == ST_FAULT) && (stateNext == ST_IDLE)) emergNext = 1'b0;
  end

  assign strobe.clrStep = (stateNext != state) || ((state == ST_SLEEP) && !modeNormal);
  assign strobe.phase   = state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      emerg <= 1'b0;
      intN  <= 1'b1;
    end else begin
      state <= stateNext;
      emerg <= emergNext;
      intN  <= ~emergNext;
    end
  end
endmodule

// File: rtl/scs_contacts.sv
`timescale 1ns/1ps
module scs_contacts
  import scs_pkg::*;
#(
  parameter int STEP_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqState_t         phase,
  input  logic [STEP_W-1:0] step,
  input  logic              hostRst,
  output logic              boostEn,
  output logic              vccEn,
  output logic              ioEn,
  output logic              clkEn,
  output logic              cardRst
);
  contactEn_t cur;
  contactEn_t nxt;
  logic       inWindow;

  assign inWindow = (step >= STEP_W'(ACT_IO_STEP)) && (step < STEP_W'(ACT_RST_STEP));

  always_comb begin
    nxt = cur;
    case (phase)
      ST_ACT: begin
        nxt.boost = 1'b1;
        nxt.vcc   = (step >= STEP_W'(ACT_VCC_STEP));
        nxt.io    = (step >= STEP_W'(ACT_IO_STEP));
        nxt.clk   = cur.clk | (inWindow & hostRst);
        nxt.rstEn = (step >= STEP_W'(ACT_RST_STEP));
      end
      ST_ON: begin
        nxt.rstEn = 1'b1;
      end
      ST_DOWN: begin
        nxt.rstEn = 1'b0;
        nxt.clk   = cur.clk   & (step < STEP_W'(DN_CLK_STEP));
        nxt.io    = cur.io    & (step < STEP_W'(DN_IO_STEP));
        nxt.vcc   = cur.vcc   & (step < STEP_W'(DN_VCC_STEP));
        nxt.boost = cur.boost & (step < STEP_W'(DN_END_STEP));
      end
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur     <= '0;
      cardRst <= 1'b0;
    end else begin
      cur     <= nxt;
      cardRst <= nxt.rstEn & ~hostRst;
    end
  end

  assign boostEn = cur.boost;
  assign vccEn   = cur.vcc;
  assign ioEn    = cur.io;
  assign clkEn   = cur.clk;
endmodule

// File: rtl/card_session_seq.sv
`timescale 1ns/1ps
module card_session_seq
  import scs_pkg::*;
#(
  parameter int TICK_CLKS      = 125,
  parameter int WAKE_CYCLES    = 96,
  parameter int TICKS_PER_SLOW = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdN,
  input  logic       modeNormal,
  input  logic       hostRst,
  input  logic       cardPresent,
  input  logic       overCurrent,
  input  logic       overTemp,
  input  logic       supplyLow,
  output logic       boostEn,
  output logic       vccEn,
  output logic       ioEn,
  output logic       clkEn,
  output logic       cardRst,
  output logic       intN,
  output logic [2:0] stateOut
);
  localparam int WAKE_TICKS = WAKE_CYCLES * TICKS_PER_SLOW;
  localparam int SEQ_MAX    = (ACT_RST_STEP > DN_END_STEP) ? ACT_RST_STEP : DN_END_STEP;
  localparam int STEP_LIMIT = (WAKE_TICKS > SEQ_MAX) ? WAKE_TICKS : SEQ_MAX;
  localparam int STEP_W     = $clog2(STEP_LIMIT + 2);

  seqStrobe_t        strobe;
  seqState_t         state;
  logic [STEP_W-1:0] step;

  scs_timebase #(.TICK_CLKS(TICK_CLKS), .STEP_W(STEP_W)) u_time (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobe.clrStep),
    .step (step)
  );

  scs_ctrl #(.STEP_W(STEP_W), .WAKE_TICKS(WAKE_TICKS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdN        (cmdN),
    .modeNormal  (modeNormal),
    .cardPresent (cardPresent),
    .overCurrent (overCurrent),
    .overTemp    (overTemp),
    .supplyLow   (supplyLow),
    .step        (step),
    .strobe      (strobe),
    .state       (state),
    .intN        (intN)
  );

  scs_contacts #(.STEP_W(STEP_W)) u_pins (
    .clk     (clk),
    .rstN    (rstN),
    .phase   (strobe.phase),
    .step    (step),
    .hostRst (hostRst),
    .boostEn (boostEn),
    .vccEn   (vccEn),
    .ioEn    (ioEn),
    .clkEn   (clkEn),
    .cardRst (cardRst)
  );

  assign stateOut = state;
endmodule

// File: rtl/card_session_seq_chk.sv
`timescale 1ns/1ps
module card_session_seq_chk
  import scs_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cmdN,
  input logic       cardPresent,
  input logic       boostEn,
  input logic       vccEn,
  input logic       ioEn,
  input logic       clkEn,
  input logic       cardRst,
  input logic       intN,
  input logic [2:0] stateOut
);
  // R2
  supply_needs_boost_chk: assert property (@(posedge clk) disable iff (!rstN)
    vccEn |-> boostEn);

  // R2
  lines_need_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioEn |-> vccEn);

  // R3
  clock_needs_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> ioEn);

  // R10
  reset_needs_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardRst |-> ioEn);

  // R4
  rise_only_in_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(boostEn) || $rose(vccEn) || $rose(ioEn) || $rose(clkEn))
      |-> ($past(stateOut) == ST_ACT));

  // R5
  fault_keeps_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_FAULT) |-> !intN);

  // R6
  int_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intN) |-> ($past(cmdN) && $past(cardPresent)));

  // R1
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_SLEEP) |-> !boostEn);
endmodule

bind card_session_seq card_session_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdN        (cmdN),
  .cardPresent (cardPresent),
  .boostEn     (boostEn),
  .vccEn       (vccEn),
  .ioEn        (ioEn),
  .clkEn       (clkEn),
  .cardRst     (cardRst),
  .intN        (intN),
  .stateOut    (stateOut)
);

// File: tb/card_session_seq_tb.sv
`timescale 1ns/1ps
module card_session_seq_tb;
  localparam int TICK = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdN = 1'b1;
  logic modeNormal = 1'b1;
  logic hostRst = 1'b0;
  logic cardPresent = 1'b1;
  logic overCurrent = 1'b0;
  logic overTemp = 1'b0;
  logic supplyLow = 1'b0;
  logic boostEn, vccEn, ioEn, clkEn, cardRst, intN;
  logic [2:0] stateOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  card_session_seq #(.TICK_CLKS(TICK), .WAKE_CYCLES(96), .TICKS_PER_SLOW(1)) u_dut (
    .clk(clk), .rstN(rstN), .cmdN(cmdN), .modeNormal(modeNormal), .hostRst(hostRst),
    .cardPresent(cardPresent), .overCurrent(overCurrent), .overTemp(overTemp),
    .supplyLow(supplyLow), .boostEn(boostEn), .vccEn(vccEn), .ioEn(ioEn),
    .clkEn(clkEn), .cardRst(cardRst), .intN(intN), .stateOut(stateOut)
  );

  typedef struct packed {
    logic [7:0] waitN;
    logic       cmdV;
    logic       rstV;
    logic [5:0] expOut;   // boost vcc io clk cardRst intN
    logic [2:0] expState;
  } row_t;

  // Samples fall mid-tick; after each check the row's inputs are driven.
  localparam row_t ROWS [17] = '{
    '{8'd1,  1'b0, 1'b0, 6'b000001, 3'd0},
    '{8'd5,  1'b0, 1'b0, 6'b100001, 3'd2},
    '{8'd16, 1'b0, 1'b0, 6'b100001, 3'd2},
    '{8'd8,  1'b0, 1'b0, 6'b110001, 3'd2},
    '{8'd16, 1'b0, 1'b1, 6'b110001, 3'd2},
    '{8'd16, 1'b0, 1'b0, 6'b110001, 3'd2},
    '{8'd8,  1'b0, 1'b1, 6'b111001, 3'd2},
    '{8'd16, 1'b0, 1'b1, 6'b111101, 3'd2},
    '{8'd24, 1'b0, 1'b1, 6'b111101, 3'd2},
    '{8'd16, 1'b0, 1'b0, 6'b111101, 3'd3},
    '{8'd8,  1'b1, 1'b0, 6'b111111, 3'd3},
    '{8'd5,  1'b1, 1'b0, 6'b111101, 3'd4},
    '{8'd8,  1'b1, 1'b0, 6'b111001, 3'd4},
    '{8'd8,  1'b1, 1'b0, 6'b110001, 3'd4},
    '{8'd8,  1'b1, 1'b0, 6'b100001, 3'd4},
    '{8'd48, 1'b1, 1'b0, 6'b100001, 3'd4},
    '{8'd8,  1'b1, 1'b0, 6'b000001, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int outVec();
    return int'({boostEn, vccEn, ioEn, clkEn, cardRst, intN});
  endfunction

  task automatic startActive();
    cmdN = 1'b0;
    waitN(130);
    chk("R1 active reached", int'(stateOut), 3);
  endtask

  task automatic releaseToIdle();
    waitN(100);
    cmdN = 1'b1;
    waitN(3);
    chk("R6 released to idle", int'(stateOut), 0);
    chk("R6 int released", int'(intN), 1);
  endtask

  initial begin
    waitN(3);
    // R9 reset state
    chk("R9 outputs in reset", outVec(), 1);
    chk("R9 state in reset", int'(stateOut), 0);
    rstN = 1'b1;
    waitN(2);
    chk("R9 idle after reset", outVec(), 1);

    // R2 R3 R4 R10 table walk
    for (int i = 0; i < 17; i++) begin
      waitN(int'(ROWS[i].waitN));
      chk($sformatf("R2/R3/R4/R10 row %0d outputs", i), outVec(), int'(ROWS[i].expOut));
      chk($sformatf("R1/R4 row %0d state", i), int'(stateOut), int'(ROWS[i].expState));
      cmdN    = ROWS[i].cmdV;
      hostRst = ROWS[i].rstV;
    end
    waitN(10);

    // R7 R5: over-current at activation tick 4
    cmdN = 1'b0;
    waitN(37);
    chk("R7 supply on before fault", int'(vccEn), 1);
    overCurrent = 1'b1;
    waitN(3);
    chk("R5 int low on fault", int'(intN), 0);
    chk("R5 deactivating", int'(stateOut), 4);
    waitN(40);
    chk("R7 lines stayed off", int'(ioEn), 0);
    chk("R7 clock stayed off", int'(clkEn), 0);
    chk("R7 reset stayed off", int'(cardRst), 0);
    overCurrent = 1'b0;
    waitN(60);
    chk("R5 fault state", int'(stateOut), 5);
    chk("R5 converter off", int'(boostEn), 0);
    waitN(20);
    chk("R6 held while cmd low", int'(stateOut), 5);
    cmdN = 1'b1;
    waitN(3);
    chk("R6 release after cmd high", int'(stateOut), 0);
    chk("R6 int high after release", int'(intN), 1);
    waitN(5);

    // R6 card removed, stays low while absent
    startActive();
    cardPresent = 1'b0;
    waitN(3);
    chk("R5 removal int low", int'(intN), 0);
    waitN(100);
    chk("R5 removal fault state", int'(stateOut), 5);
    cmdN = 1'b1;
    waitN(20);
    chk("R6 absent card keeps fault", int'(stateOut), 5);
    chk("R6 absent card keeps int low", int'(intN), 0);
    cardPresent = 1'b1;
    waitN(3);
    chk("R6 card back releases", int'(intN), 1);
    chk("R6 card back idle", int'(stateOut), 0);
    waitN(5);

    // R5 over-temperature
    startActive();
    overTemp = 1'b1;
    waitN(3);
    chk("R5 overtemp int low", int'(intN), 0);
    chk("R5 overtemp deact", int'(stateOut), 4);
    overTemp = 1'b0;
    releaseToIdle();

    // R5 supply low
    startActive();
    supplyLow = 1'b1;
    waitN(3);
    chk("R5 supply low int", int'(intN), 0);
    chk("R5 supply low deact", int'(stateOut), 4);
    supplyLow = 1'b0;
    releaseToIdle();

    // R8 sleep from active, R1 no activation while asleep
    startActive();
    modeNormal = 1'b0;
    waitN(3);
    chk("R8 normal deact on sleep", int'(stateOut), 4);
    chk("R8 int stays high", int'(intN), 1);
    waitN(100);
    chk("R8 low-power entered", int'(stateOut), 1);
    waitN(200);
    chk("R1 no activation asleep", int'(stateOut), 1);
    chk("R1 converter off asleep", int'(boostEn), 0);
    modeNormal = 1'b1;
    waitN(700);
    chk("R8 still waking", int'(stateOut), 1);
    waitN(80);
    chk("R1 R8 activation after wake", int'(stateOut), 2);
    cmdN = 1'b1;
    waitN(120);
    chk("R4 back to idle", int'(stateOut), 0);

    // R8 wake count restarts on a low pulse
    modeNormal = 1'b0;
    waitN(3);
    chk("R8 idle to low-power", int'(stateOut), 1);
    cmdN = 1'b0;
    waitN(20);
    modeNormal = 1'b1;
    waitN(200);
    modeNormal = 1'b0;
    waitN(10);
    modeNormal = 1'b1;
    waitN(700);
    chk("R8 count restarted", int'(stateOut), 1);
    waitN(80);
    chk("R1 mode high with cmd low", int'(stateOut), 2);
    cmdN = 1'b1;
    waitN(120);
    chk("R4 idle at end", int'(stateOut), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule